// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block turns a 32-bit physical address into a choice among four SDRAM chip selects. Software programs each chip select through two 32-bit registers. One register holds the base, in 16 MiB steps. The other holds the span, also in 16 MiB steps, together with an enable flag. Every cycle the block compares the CPU address against all usable windows. It reports whether any window matched, which chip select was chosen, and an active-low attribute nibble in which only the chosen chip select's bit is zero.

Some windows cannot be used. A window is unusable if it is disabled, or if its base carries any address bit above bit 31. Unusable windows never match. The block also publishes a live mask of the usable chip selects and a count of them, so that downstream logic can see the memory layout without reading the registers.

Top module: `dram_cs_decoder`

## Requirements
- R1: After reset every register reads 0, `cs_hit` is 0, `cs_index` is 0, `cs_attr` is 4'hF, `usable_mask` is 0 and `usable_cnt` is 0.
- R2: Registers are addressed by `reg_addr[4:2]`, and `reg_addr[1:0]` is ignored. Window n keeps its base register at byte offset n*8 and its size register at n*8+4. `reg_rdata` returns the addressed register's full stored value in the same cycle.
- R3: Bit 0 of a window's size register enables that window. When the bit is 0, the window never matches and is not usable.
- R4: A window whose base register has any of bits 3:0 set holds an address above 4 GiB. Such a window never matches and is not usable, even when it is enabled.
- R5: A usable window covers addresses from B to B+S-1, where B is base bits 31:24 followed by 24 zero bits. S is the size register with bits 23:0 forced to ones, plus one. Base bits 23:4 have no effect on decoding. A window that reaches past 4 GiB covers everything up to 32'hFFFF_FFFF.
- R6: When window i matches, `cs_hit` is 1, `cs_index` is i, and `cs_attr` is 4'hF with only bit i cleared (window 0 gives 4'hE, 1 gives 4'hD, 2 gives 4'hB, 3 gives 4'h7).
- R7: When several usable windows match, the lowest-numbered window is chosen.
- R8: When no usable window matches, `cs_hit` is 0, `cs_index` is 0 and `cs_attr` is 4'hF.
- R9: Bit i of `usable_mask` is 1 exactly when window i is enabled and has base bits 3:0 all zero. `usable_cnt` equals the number of ones in `usable_mask`.
- R10: A register write is accepted on the rising edge at which `reg_we` is high. Decoding and the usable mask reflect it from the following cycle and not before.
- R11: Size register bits 4:2 hold a chip-select number field. These bits, and all other bits outside 31:24 and 0, are stored and read back but have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed register contents |
| cpu_addr | input | 32 | Physical address to decode |
| cs_hit | output | 1 | A usable window matched |
| cs_index | output | 2 | Chosen chip select |
| cs_attr | output | 4 | Active-low chip-select attribute |
| usable_mask | output | 4 | Usable chip selects |
| usable_cnt | output | 3 | Number of usable chip selects |

## Verification
The assertions check the following on every cycle:
- A hit clears exactly one attribute bit, at the chosen index.
- A miss leaves the attribute all ones and the index at zero.
- The chosen window is always a usable one.
- The count agrees with the mask.
- A write to window 0's enable bit appears in the mask on the next cycle.

Some properties can only be shown by the bench's directed scenarios:
- The window end points, computed from the size encoding.
- The rejection of bases above 4 GiB.
- Lowest-index priority among overlapping windows.
- The coverage of a window that wraps past the top of the address space.
- The lack of effect of the chip-select number field and of the low base bits.

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder #(
  parameter int NUM_WIN = 4,
  localparam int IW  = $clog2(NUM_WIN),
  localparam int RAW = $clog2(NUM_WIN * 8),
  localparam int CW  = $clog2(NUM_WIN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [31:0]    cpu_addr,
  output logic           cs_hit,
  output logic [IW-1:0]  cs_index,
  output logic [NUM_WIN-1:0] cs_attr,
  output logic [NUM_WIN-1:0] usable_mask,
  output logic [CW-1:0]  usable_cnt
);

  logic [31:0] base_q [NUM_WIN];
  logic [31:0] size_q [NUM_WIN];
  logic [NUM_WIN-1:0] match;

  wire [IW-1:0] wsel    = reg_addr[RAW-1:3];
  wire          sel_siz = reg_addr[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else if (reg_we) begin
      if (sel_siz) size_q[wsel] <= reg_wdata;
      else         base_q[wsel] <= reg_wdata;
    end
  end

  assign reg_rdata = sel_siz ? size_q[wsel] : base_q[wsel];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    wire [8:0] off = {1'b0, cpu_addr[31:24]} - {1'b0, base_q[i][31:24]};
    assign usable_mask[i] = size_q[i][0] && (base_q[i][3:0] == 4'h0);
    assign match[i] = usable_mask[i]
                   && (cpu_addr[31:24] >= base_q[i][31:24])
                   && (off <= {1'b0, size_q[i][31:24]});
  end

  always_comb begin
    cs_hit   = 1'b0;
    cs_index = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        cs_hit   = 1'b1;
        cs_index = IW'(i);
      end
    end
  end

  always_comb begin
    cs_attr = '1;
    if (cs_hit) cs_attr[cs_index] = 1'b0;
  end

  always_comb begin
    usable_cnt = '0;
    for (int i = 0; i < NUM_WIN; i++) usable_cnt = usable_cnt + CW'(usable_mask[i]);
  end

  a_r6_attr_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hit |-> ($countones(cs_attr) == NUM_WIN - 1 && !cs_attr[cs_index]));

  a_r8_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hit |-> (&cs_attr && cs_index == '0));

  a_r4_hit_is_usable: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hit |-> usable_mask[cs_index]);

  a_r9_count_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    usable_cnt == CW'($countones(usable_mask)));

  a_r10_enable_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[2] && reg_addr[RAW-1:3] == '0)
      |=> (usable_mask[0] == ($past(reg_wdata[0]) && base_q[0][3:0] == 4'h0)));

endmodule

// File: tb/dram_cs_decoder_bench.sv
module dram_cs_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        cs_hit;
  logic [1:0]  cs_index;
  logic [3:0]  cs_attr;
  logic [3:0]  usable_mask;
  logic [2:0]  usable_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dram_cs_decoder u_dram_cs_decoder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .cs_hit(cs_hit), .cs_index(cs_index), .cs_attr(cs_attr),
    .usable_mask(usable_mask), .usable_cnt(usable_cnt));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic dec(input string tag, input logic [31:0] a, input logic hit,
                     input logic [1:0] idx, input logic [3:0] attr);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk({tag, " hit"}, 32'(cs_hit), 32'(hit));
    chk({tag, " index"}, 32'(cs_index), 32'(idx));
    chk({tag, " attr"}, 32'(cs_attr), 32'(attr));
  endtask

  task automatic t_reset;
    chk("R1 mask", 32'(usable_mask), 0);
    chk("R1 count", 32'(usable_cnt), 0);
    for (int i = 0; i < 8; i++) rd("R1 register zero", 5'(i * 4), 0);
    dec("R1 idle decode", 32'h0000_0000, 1'b0, 2'd0, 4'hF);
  endtask

  task automatic t_basic;
    wr(5'h00, 32'h0000_0000);
    wr(5'h04, 32'h0F00_0001);
    dec("R5 win0 top edge", 32'h0FFF_FFFF, 1'b1, 2'd0, 4'hE);
    dec("R8 past win0", 32'h1000_0000, 1'b0, 2'd0, 4'hF);
    wr(5'h08, 32'h1012_3450);
    wr(5'h0C, 32'h0F00_0001);
    dec("R5 low base bits ignored", 32'h1000_0000, 1'b1, 2'd1, 4'hD);
    dec("R6 win1 attr", 32'h1800_0000, 1'b1, 2'd1, 4'hD);
    rd("R2 base readback", 5'h08, 32'h1012_3450);
    rd("R2 low addr bits ignored", 5'h0E, 32'h0F00_0001);
  endtask

  task automatic t_high_base;
    wr(5'h10, 32'h2000_0001);
    wr(5'h14, 32'h0F00_0001);
    dec("R4 high base never hits", 32'h2000_0000, 1'b0, 2'd0, 4'hF);
    chk("R4 mask excludes high base", 32'(usable_mask), 32'h3);
    chk("R9 count two", 32'(usable_cnt), 2);
  endtask

  task automatic t_overlap;
    wr(5'h18, 32'h0800_0000);
    wr(5'h1C, 32'hFF00_0001);
    chk("R9 mask three", 32'(usable_mask), 32'hB);
    chk("R9 count three", 32'(usable_cnt), 3);
    dec("R7 overlap picks win0", 32'h0900_0000, 1'b1, 2'd0, 4'hE);
    dec("R7 overlap picks win1", 32'h1100_0000, 1'b1, 2'd1, 4'hD);
    dec("R6 win3 attr", 32'h2000_0000, 1'b1, 2'd3, 4'h7);
    dec("R5 wrap to top", 32'hFFFF_FFFF, 1'b1, 2'd3, 4'h7);
    dec("R7 below win3 still win0", 32'h0700_0000, 1'b1, 2'd0, 4'hE);
  endtask

  task automatic t_disable;
    @(negedge clk);
    cpu_addr = 32'h0900_0000;
    reg_we = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h0F00_0000;
    #1 chk("R10 no effect before edge", 32'(cs_index), 0);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    chk("R3 disabled win0 falls to win3", 32'(cs_index), 3);
    chk("R10 mask updated next cycle", 32'(usable_mask), 32'hA);
    dec("R3 disabled range misses", 32'h0100_0000, 1'b0, 2'd0, 4'hF);
  endtask

  task automatic t_cs_field;
    wr(5'h0C, 32'h0F00_001D);
    rd("R11 size readback", 5'h0C, 32'h0F00_001D);
    dec("R11 field no effect", 32'h1F00_0000, 1'b1, 2'd1, 4'hD);
    dec("R11 end unchanged", 32'h2000_0000, 1'b1, 2'd3, 4'h7);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_high_base();
    t_overlap();
    t_disable();
    t_cs_field();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule